// File: doc/BRIEF.md
# Packed/Scalar SIMD Integer Execute Unit

This block is a compact vector integer datapath. It holds eight 128-bit registers, each seen as four 32-bit lanes. Lane 0 sits in bits 31:0. One instruction names two source registers, a destination and an operation. In packed form the operation runs on all four lane pairs side by side. In scalar form only lane 0 is computed, and lanes 1 to 3 of the result are taken unchanged from the first source. Every lane wraps modulo 2^32.

A single load/store port moves whole registers to and from an external memory. The address comes from a separate integer input and never from the vector registers. An access must sit on a 16-byte boundary unless the request is flagged as unaligned. A misaligned access raises a one-cycle fault and is dropped.

A small control/status word holds exception mask bits, a rounding-mode field, a flush-to-zero enable and two sticky flags. The sticky flags record signed lane overflow and misalignment.

Top module: `simd_exec_unit`

## Requirements
- R1: After reset all eight registers read as zero, and the control/status word reads 0.
- R2: With opScalar low, the operation is applied to all four 32-bit lane pairs, and each lane wraps modulo 2^32. The result is written to opDst on the clock edge that samples opValid.
- R3: With opScalar high, only lane 0 of the destination gets the result. Lanes 1 to 3 (bits 127:32) are copied from the first source register (opSrcA).
- R4: opKind encodes ADD=0, SUB=1 (A minus B), AND=2, OR=3 and XOR=4. The codes 5, 6 and 7 leave every register unchanged.
- R5: Register reads are combinational. A read in the same cycle as a write to that register returns the value from before the write.
- R6: An access with memUnaligned low and any of memAddr[3:0] set drives misalignFault high for exactly the one cycle after the request. Such an access writes no register and does not raise memWrEn.
- R7: An access with memUnaligned high goes ahead at any address. A load writes memRdData into memReg. A store drives memWrEn, memWrAddr and the contents of memReg in the cycle after the request.
- R8: The overflow flag (status bit 7) is set when an ADD or SUB produces signed overflow in any computed lane, while mask bit 0 is clear. Scalar operations consider lane 0 only. The flag stays set afterwards.
- R9: Writing a 1 to a status flag bit clears it. When a clearing write and a new flag event fall in the same cycle, the flag stays set.
- R10: The rounding field (bits 5:4), the flush-to-zero bit (bit 6) and the mask bits (3:0) read back as written. The rounding and flush-to-zero settings do not change any result.
- R11: If a load and an operation target the same register in one cycle, the load data is the value stored.
- R12: The misalign flag (status bit 8) is set together with misalignFault while mask bit 1 is clear. With mask bit 1 set, the fault still occurs but the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Execute an operation this cycle |
| opKind | input | 3 | Operation code |
| opScalar | input | 1 | 1 = scalar (lane 0 only), 0 = packed |
| opSrcA | input | 3 | First source register |
| opSrcB | input | 3 | Second source register |
| opDst | input | 3 | Destination register |
| memValid | input | 1 | Memory access request |
| memWrite | input | 1 | 1 = store, 0 = load |
| memUnaligned | input | 1 | Access is flagged as unaligned |
| memAddr | input | 32 | Byte address of the access |
| memReg | input | 3 | Register loaded or stored |
| memRdData | input | 128 | Load data |
| memWrEn | output | 1 | Store strobe, one cycle after the request |
| memWrAddr | output | 32 | Store address |
| memWrData | output | 128 | Store data |
| misalignFault | output | 1 | One-cycle misalignment fault pulse |
| csrWrEn | input | 1 | Write the control/status word |
| csrWrData | input | 9 | Control/status write data |
| csrRdData | output | 9 | Control/status word |

## Verification
Two things can land in one cycle. An arithmetic write-back and a load can both hit the register file, and a software write that clears a flag can meet a new overflow that sets it. The bench issues an operation and a load to the same destination in one cycle. It then stores that register and expects the load data. It also issues an overflowing ADD in the same cycle as a flag-clearing write and expects the overflow flag to read 1 afterwards. A store of the register being written in the same cycle must return the old contents.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int OPK_W = 3;
  localparam logic [OPK_W-1:0] OP_ADD = 3'd0;
  localparam logic [OPK_W-1:0] OP_SUB = 3'd1;
  localparam logic [OPK_W-1:0] OP_AND = 3'd2;
  localparam logic [OPK_W-1:0] OP_OR  = 3'd3;
  localparam logic [OPK_W-1:0] OP_XOR = 3'd4;

  // control/status word layout
  localparam int CSR_W        = 9;
  localparam int MASK_W       = 4;
  localparam int BIT_MASK_OVF = 0;
  localparam int BIT_MASK_MIS = 1;
  localparam int BIT_ROUND_LO = 4;
  localparam int BIT_FTZ      = 6;
  localparam int BIT_FLAG_OVF = 7;
  localparam int BIT_FLAG_MIS = 8;

  typedef struct packed {
    logic opWe;
    logic loadWe;
    logic storeEn;
  } strobes_t;

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic [OPK_W-1:0]  kind,
  output logic [LANE_W-1:0] laneY,
  output logic              laneOvf
);

  localparam int MSB = LANE_W - 1;

  always_comb begin
    laneY   = '0;
    laneOvf = 1'b0;
    case (kind)
      OP_ADD: begin
        laneY   = laneA + laneB;
        laneOvf = (laneA[MSB] == laneB[MSB]) && (laneY[MSB] != laneA[MSB]);
      end
      OP_SUB: begin
        laneY   = laneA - laneB;
        laneOvf = (laneA[MSB] != laneB[MSB]) && (laneY[MSB] != laneA[MSB]);
      end
      OP_AND:  laneY = laneA & laneB;
      OP_OR:   laneY = laneA | laneB;
      OP_XOR:  laneY = laneA ^ laneB;
      default: laneY = '0;
    endcase
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int LANES    = 4,
  parameter int LANE_W   = 32,
  parameter int ADDR_W   = 32,
  localparam int VEC_W     = LANES * LANE_W,
  localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [OPK_W-1:0]     opKind,
  input  logic                 opScalar,
  input  logic [REG_IDX_W-1:0] opSrcA,
  input  logic [REG_IDX_W-1:0] opSrcB,
  input  logic [REG_IDX_W-1:0] opDst,
  input  logic [REG_IDX_W-1:0] memReg,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [VEC_W-1:0]     memRdData,
  output logic [LANES-1:0]     laneOvf,
  output logic                 memWrEn,
  output logic [ADDR_W-1:0]    memWrAddr,
  output logic [VEC_W-1:0]     memWrData
);

  logic [VEC_W-1:0] regFile [NUM_REGS];
  logic [VEC_W-1:0] opndA, opndB, storeData, merged;

  assign opndA     = regFile[opSrcA];
  assign opndB     = regFile[opSrcB];
  assign storeData = regFile[memReg];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] aluY;
    simd_lane_alu #(.LANE_W(LANE_W)) u_alu (
      .laneA   (opndA[l*LANE_W +: LANE_W]),
      .laneB   (opndB[l*LANE_W +: LANE_W]),
      .kind    (opKind),
      .laneY   (aluY),
      .laneOvf (laneOvf[l])
    );
    if (l == 0) begin : g_low
      assign merged[l*LANE_W +: LANE_W] = aluY;
    end else begin : g_high
      assign merged[l*LANE_W +: LANE_W] =
        opScalar ? opndA[l*LANE_W +: LANE_W] : aluY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else begin
      if (strobes.opWe)   regFile[opDst]  <= merged;
      // load is assigned last so it wins a same-register collision
      if (strobes.loadWe) regFile[memReg] <= memRdData;
      memWrEn <= strobes.storeEn;
      if (strobes.storeEn) begin
        memWrAddr <= memAddr;
        memWrData <= storeData;
      end
    end
  end

endmodule

// File: rtl/simd_control.sv
module simd_control
  import simd_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int ALIGN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [OPK_W-1:0]      opKind,
  input  logic                  opScalar,
  input  logic                  memValid,
  input  logic                  memWrite,
  input  logic                  memUnaligned,
  input  logic [ALIGN_BITS-1:0] memAddrLow,
  input  logic [LANES-1:0]      laneOvf,
  input  logic                  csrWrEn,
  input  logic [CSR_W-1:0]      csrWrData,
  output strobes_t              strobes,
  output logic                  misalignFault,
  output logic [CSR_W-1:0]      csrRdData
);

  logic [MASK_W-1:0] maskBits;
  logic [1:0]        roundMode;
  logic              flushZero, ovfFlag, misFlag;
  logic              misalignHit, arith, ovfHit;
  logic [LANES-1:0]  laneActive;

  assign misalignHit = memValid && !memUnaligned && (memAddrLow != '0);
  assign arith       = (opKind == OP_ADD) || (opKind == OP_SUB);
  assign laneActive  = opScalar ? LANES'(1) : '1;

  always_comb begin
    strobes.opWe    = opValid && (opKind <= OP_XOR);
    strobes.loadWe  = memValid && !memWrite && !misalignHit;
    strobes.storeEn = memValid && memWrite && !misalignHit;
  end

  assign ovfHit = strobes.opWe && arith && |(laneOvf & laneActive)
                  && !maskBits[BIT_MASK_OVF];

  assign csrRdData = {misFlag, ovfFlag, flushZero, roundMode, maskBits};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskBits      <= '0;
      roundMode     <= '0;
      flushZero     <= 1'b0;
      ovfFlag       <= 1'b0;
      misFlag       <= 1'b0;
      misalignFault <= 1'b0;
    end else begin
      misalignFault <= misalignHit;
      if (csrWrEn) begin
        maskBits  <= csrWrData[MASK_W-1:0];
        roundMode <= csrWrData[BIT_ROUND_LO +: 2];
        flushZero <= csrWrData[BIT_FTZ];
        if (csrWrData[BIT_FLAG_OVF]) ovfFlag <= 1'b0;
        if (csrWrData[BIT_FLAG_MIS]) misFlag <= 1'b0;
      end
      // a new event overrides a clear in the same cycle
      if (ovfHit) ovfFlag <= 1'b1;
      if (misalignHit && !maskBits[BIT_MASK_MIS]) misFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int LANES       = 4,
  parameter int LANE_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 16,
  localparam int VEC_W      = LANES * LANE_W,
  localparam int REG_IDX_W  = $clog2(NUM_REGS),
  localparam int ALIGN_BITS = $clog2(ALIGN_BYTES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic [OPK_W-1:0]     opKind,
  input  logic                 opScalar,
  input  logic [REG_IDX_W-1:0] opSrcA,
  input  logic [REG_IDX_W-1:0] opSrcB,
  input  logic [REG_IDX_W-1:0] opDst,
  input  logic                 memValid,
  input  logic                 memWrite,
  input  logic                 memUnaligned,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [REG_IDX_W-1:0] memReg,
  input  logic [VEC_W-1:0]     memRdData,
  output logic                 memWrEn,
  output logic [ADDR_W-1:0]    memWrAddr,
  output logic [VEC_W-1:0]     memWrData,
  output logic                 misalignFault,
  input  logic                 csrWrEn,
  input  logic [CSR_W-1:0]     csrWrData,
  output logic [CSR_W-1:0]     csrRdData
);

  strobes_t         strobes;
  logic [LANES-1:0] laneOvf;

  simd_control #(.LANES(LANES), .ALIGN_BITS(ALIGN_BITS)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .opValid       (opValid),
    .opKind        (opKind),
    .opScalar      (opScalar),
    .memValid      (memValid),
    .memWrite      (memWrite),
    .memUnaligned  (memUnaligned),
    .memAddrLow    (memAddr[ALIGN_BITS-1:0]),
    .laneOvf       (laneOvf),
    .csrWrEn       (csrWrEn),
    .csrWrData     (csrWrData),
    .strobes       (strobes),
    .misalignFault (misalignFault),
    .csrRdData     (csrRdData)
  );

  simd_datapath #(
    .NUM_REGS(NUM_REGS), .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opKind    (opKind),
    .opScalar  (opScalar),
    .opSrcA    (opSrcA),
    .opSrcB    (opSrcB),
    .opDst     (opDst),
    .memReg    (memReg),
    .memAddr   (memAddr),
    .memRdData (memRdData),
    .laneOvf   (laneOvf),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/simd_exec_unit_chk.sv
module simd_exec_unit_chk
  import simd_pkg::*;
#(
  parameter int ALIGN_BITS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  opValid,
  input logic [OPK_W-1:0]      opKind,
  input logic                  memValid,
  input logic                  memWrite,
  input logic                  memUnaligned,
  input logic [ALIGN_BITS-1:0] memAddrLow,
  input logic                  memWrEn,
  input logic                  misalignFault,
  input logic                  csrWrEn,
  input logic [CSR_W-1:0]      csrRdData
);

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> $past(memValid && !memUnaligned && (memAddrLow != '0)));

  // R6
  fault_blocks_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> !memWrEn);

  // R7
  store_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memValid && memWrite));

  // R8
  ovf_flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csrRdData[BIT_FLAG_OVF]) |->
      $past(opValid && (opKind == OP_ADD || opKind == OP_SUB)
            && !csrRdData[BIT_MASK_OVF]));

  // R12
  mis_flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csrRdData[BIT_FLAG_MIS]) |-> misalignFault);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(csrWrEn) |-> $stable(csrRdData[BIT_FTZ:BIT_ROUND_LO]));

endmodule

bind simd_exec_unit simd_exec_unit_chk #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .opValid       (opValid),
  .opKind        (opKind),
  .memValid      (memValid),
  .memWrite      (memWrite),
  .memUnaligned  (memUnaligned),
  .memAddrLow    (memAddr[ALIGN_BITS-1:0]),
  .memWrEn       (memWrEn),
  .misalignFault (misalignFault),
  .csrWrEn       (csrWrEn),
  .csrRdData     (csrRdData)
);

// File: tb/simd_exec_unit_tb.sv
`timescale 1ns/1ps
module simd_exec_unit_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [2:0]   opKind = '0;
  logic         opScalar = 1'b0;
  logic [2:0]   opSrcA = '0, opSrcB = '0, opDst = '0;
  logic         memValid = 1'b0, memWrite = 1'b0, memUnaligned = 1'b0;
  logic [31:0]  memAddr = '0;
  logic [2:0]   memReg = '0;
  logic [127:0] memRdData = '0;
  logic         memWrEn;
  logic [31:0]  memWrAddr;
  logic [127:0] memWrData;
  logic         misalignFault;
  logic         csrWrEn = 1'b0;
  logic [8:0]   csrWrData = '0;
  logic [8:0]   csrRdData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  simd_exec_unit u_dut (.*);

  localparam logic [127:0] VA = {32'h7FFFFFFF, 32'h80000000, 32'h12345678, 32'hFFFFFFFF};
  localparam logic [127:0] VB = {32'h00000001, 32'h00000001, 32'h0F0F0F0F, 32'h00000002};

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] laneModel(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [127:0] vecModel(input logic [2:0] k, input logic sc, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int l = 0; l < 4; l++)
      r[l*32 +: 32] = (sc && l > 0) ? a[l*32 +: 32] : laneModel(k, a[l*32 +: 32], b[l*32 +: 32]);
    return r;
  endfunction

  function automatic logic ovfModel(input logic [2:0] k, input logic sc, input logic [127:0] a, input logic [127:0] b);
    logic o = 1'b0;
    for (int l = 0; l < 4; l++) begin
      logic [31:0] x = a[l*32 +: 32];
      logic [31:0] y = b[l*32 +: 32];
      logic [31:0] s = laneModel(k, x, y);
      if (!(sc && l > 0)) begin
        if (k == 3'd0 && x[31] == y[31] && s[31] != x[31]) o = 1'b1;
        if (k == 3'd1 && x[31] != y[31] && s[31] != x[31]) o = 1'b1;
      end
    end
    return o;
  endfunction

  task automatic idle();
    opValid = 1'b0; memValid = 1'b0; csrWrEn = 1'b0; memUnaligned = 1'b0;
  endtask

  task automatic doLoad(input logic [2:0] r, input logic [127:0] d, input logic [31:0] a,
                        input logic un, output logic flt);
    @(negedge clk);
    memValid = 1'b1; memWrite = 1'b0; memReg = r; memRdData = d; memAddr = a; memUnaligned = un;
    @(posedge clk); #1;
    flt = misalignFault;
    idle();
  endtask

  task automatic doStore(input logic [2:0] r, input logic [31:0] a, input logic un,
                         output logic we, output logic [127:0] d, output logic [31:0] wa, output logic flt);
    @(negedge clk);
    memValid = 1'b1; memWrite = 1'b1; memReg = r; memAddr = a; memUnaligned = un;
    @(posedge clk); #1;
    we = memWrEn; d = memWrData; wa = memWrAddr; flt = misalignFault;
    idle();
  endtask

  task automatic readReg(input logic [2:0] r, output logic [127:0] d);
    logic we, flt;
    logic [31:0] wa;
    doStore(r, 32'h200, 1'b0, we, d, wa, flt);
    if (!we) d = 'x;
  endtask

  task automatic doOp(input logic [2:0] k, input logic sc, input logic [2:0] a,
                      input logic [2:0] b, input logic [2:0] dst);
    @(negedge clk);
    opValid = 1'b1; opKind = k; opScalar = sc; opSrcA = a; opSrcB = b; opDst = dst;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic writeCsr(input logic [8:0] v);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = v;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic testReset();
    logic [127:0] d;
    check("R1 csr after reset", 128'(csrRdData), 128'h0);
    for (int r = 0; r < 8; r++) begin
      readReg(3'(r), d);
      check($sformatf("R1 reg%0d after reset", r), d, 128'h0);
    end
  endtask

  task automatic testOps(input logic sc);
    logic [127:0] d;
    logic flt;
    doLoad(3'd1, VA, 32'h100, 1'b0, flt);
    doLoad(3'd2, VB, 32'h110, 1'b0, flt);
    for (int k = 0; k < 5; k++) begin
      writeCsr(9'h180);
      doOp(3'(k), sc, 3'd1, 3'd2, 3'd3);
      readReg(3'd3, d);
      check($sformatf("%s R4 op%0d result", sc ? "R3 scalar" : "R2 packed", k), d,
            vecModel(3'(k), sc, VA, VB));
      check($sformatf("R8 overflow flag op%0d sc%0d", k, sc), 128'(csrRdData[7]),
            128'(ovfModel(3'(k), sc, VA, VB)));
    end
  endtask

  task automatic testBadCode();
    logic [127:0] d;
    logic flt;
    doLoad(3'd5, 128'hA5A5, 32'h0, 1'b0, flt);
    for (int k = 5; k < 8; k++) begin
      doOp(3'(k), 1'b0, 3'd1, 3'd2, 3'd5);
      readReg(3'd5, d);
      check($sformatf("R4 code %0d ignored", k), d, 128'hA5A5);
    end
  endtask

  task automatic testReadBeforeWrite();
    logic [127:0] d;
    logic flt;
    doLoad(3'd6, 128'h1111, 32'h0, 1'b0, flt);
    @(negedge clk);
    opValid = 1'b1; opKind = 3'd4; opScalar = 1'b0; opSrcA = 3'd1; opSrcB = 3'd2; opDst = 3'd6;
    memValid = 1'b1; memWrite = 1'b1; memReg = 3'd6; memAddr = 32'h40;
    @(posedge clk); #1;
    check("R5 same-cycle store sees old", memWrData, 128'h1111);
    idle();
    readReg(3'd6, d);
    check("R5 new value afterwards", d, VA ^ VB);
  endtask

  task automatic testMisalign();
    logic [127:0] d;
    logic [31:0] wa;
    logic flt, we;
    writeCsr(9'h180);
    doLoad(3'd7, 128'h77, 32'h100, 1'b0, flt);
    doLoad(3'd7, 128'hBAD, 32'h104, 1'b0, flt);
    check("R6 load fault pulse", 128'(flt), 128'h1);
    check("R12 misalign flag set", 128'(csrRdData[8]), 128'h1);
    @(posedge clk); #1;
    check("R6 fault lasts one cycle", 128'(misalignFault), 128'h0);
    readReg(3'd7, d);
    check("R6 no register write", d, 128'h77);
    doStore(3'd7, 32'h108, 1'b0, we, d, wa, flt);
    check("R6 store fault", 128'(flt), 128'h1);
    check("R6 store suppressed", 128'(we), 128'h0);
    writeCsr(9'h182);
    check("R9 misalign flag cleared", 128'(csrRdData[8]), 128'h0);
    doLoad(3'd7, 128'hBAD, 32'h10F, 1'b0, flt);
    check("R12 masked still faults", 128'(flt), 128'h1);
    check("R12 masked flag stays clear", 128'(csrRdData[8]), 128'h0);
    writeCsr(9'h180);
  endtask

  task automatic testUnaligned();
    logic [127:0] d;
    logic [31:0] wa;
    logic flt, we;
    doLoad(3'd7, 128'hC0FFEE, 32'h3, 1'b1, flt);
    check("R7 unaligned load no fault", 128'(flt), 128'h0);
    readReg(3'd7, d);
    check("R7 unaligned load data", d, 128'hC0FFEE);
    doStore(3'd7, 32'h7, 1'b1, we, d, wa, flt);
    check("R7 unaligned store strobe", 128'(we), 128'h1);
    check("R7 unaligned store addr", 128'(wa), 128'h7);
    check("R7 unaligned store data", d, 128'hC0FFEE);
  endtask

  task automatic testFlags();
    writeCsr(9'h181);
    doOp(3'd0, 1'b0, 3'd1, 3'd2, 3'd3);
    check("R8 masked overflow not flagged", 128'(csrRdData[7]), 128'h0);
    writeCsr(9'h180);
    doOp(3'd0, 1'b0, 3'd1, 3'd2, 3'd3);
    check("R8 overflow flag set", 128'(csrRdData[7]), 128'h1);
    doOp(3'd2, 1'b0, 3'd1, 3'd2, 3'd3);
    check("R8 flag is sticky", 128'(csrRdData[7]), 128'h1);
    writeCsr(9'h080);
    check("R9 write one clears", 128'(csrRdData[7]), 128'h0);
    @(negedge clk);
    opValid = 1'b1; opKind = 3'd0; opScalar = 1'b0; opSrcA = 3'd1; opSrcB = 3'd2; opDst = 3'd3;
    csrWrEn = 1'b1; csrWrData = 9'h080;
    @(posedge clk); #1;
    idle();
    check("R9 set beats clear", 128'(csrRdData[7]), 128'h1);
  endtask

  task automatic testModes();
    logic [127:0] d;
    writeCsr(9'h1FC);
    check("R10 fields read back", 128'(csrRdData), 128'h07C);
    doOp(3'd0, 1'b0, 3'd1, 3'd2, 3'd4);
    readReg(3'd4, d);
    check("R10 modes do not alter result", d, vecModel(3'd0, 1'b0, VA, VB));
    writeCsr(9'h180);
  endtask

  task automatic testCollide();
    logic [127:0] d;
    @(negedge clk);
    opValid = 1'b1; opKind = 3'd0; opScalar = 1'b0; opSrcA = 3'd1; opSrcB = 3'd2; opDst = 3'd0;
    memValid = 1'b1; memWrite = 1'b0; memReg = 3'd0; memAddr = 32'h20; memRdData = 128'hD00D;
    @(posedge clk); #1;
    idle();
    readReg(3'd0, d);
    check("R11 load wins same register", d, 128'hD00D);
    @(negedge clk);
    opValid = 1'b1; opKind = 3'd3; opDst = 3'd4;
    memValid = 1'b1; memWrite = 1'b0; memReg = 3'd5; memAddr = 32'h30; memRdData = 128'hBEEF;
    @(posedge clk); #1;
    idle();
    readReg(3'd4, d);
    check("R11 op lands on other register", d, VA | VB);
    readReg(3'd5, d);
    check("R11 load lands on other register", d, 128'hBEEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    testReset();
    testOps(1'b0);
    testOps(1'b1);
    testBadCode();
    testReadBeforeWrite();
    testMisalign();
    testUnaligned();
    testFlags();
    testModes();
    testCollide();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule